// File: doc/BRIEF.md
# External Clock Failure Monitor

This block runs in the always-on internal RC reference clock domain and watches a free-running external oscillator for loss of activity. The external clock is brought into the reference domain through a synchroniser. A watch counter measures how many consecutive reference cycles pass without a synchronised transition. When that gap reaches a parameterised limit, the external oscillator is declared dead.

Software arms the block with an enable bit, but the block only watches while the oscillator is both switched on and reporting ready. Switching the oscillator off disarms it at once. A detected failure has three effects. The oscillator's effective enable is forced off until software withdraws its own enable. A one-cycle break pulse goes to an advanced timer. A sticky flag, meant for the non-maskable interrupt line, is set and holds until software pulses a write-one clear.

Top module: `ext_clk_fail_mon`

## Requirements
- R1: After reset, `brk_pulse` and `nmi_flag` are 0, and `osc_enable` equals `sw_osc_on`.
- R2: `mon_active` is 1 exactly when `mon_enable`, `osc_ready` and `osc_enable` are all 1.
- R3: A failure is declared on the TIMEOUT-th consecutive cycle in which `mon_active` is 1 and no synchronised external edge is seen; `brk_pulse` is 1 in the cycle that follows.
- R4: A synchronised external edge restarts the gap count, so a clock whose edges arrive more often than every TIMEOUT cycles never causes a failure.
- R5: `brk_pulse` lasts exactly one reference cycle per failure.
- R6: A failure forces `osc_enable` to 0 from the cycle after it. The output stays 0 while `sw_osc_on` stays 1. Once `sw_osc_on` is dropped and raised again, `osc_enable` follows it.
- R7: Dropping `sw_osc_on` disarms the monitor at once, and a stopped external clock then raises no failure.
- R8: A failure sets `nmi_flag`. The flag stays 1 until `flag_clr` is 1 on a clock edge, and it reads 0 in the cycle after that edge.
- R9: If `flag_clr` arrives on the same edge as a new failure, the failure wins and `nmi_flag` stays 1. The clear takes effect only once monitoring has already been disarmed.
- R10: While `osc_ready` is 0 or `mon_enable` is 0, a stopped external clock causes no failure.
- R11: With EDGE_MODE set to both edges, falling transitions restart the count as well as rising ones. A clock whose half period is shorter than TIMEOUT cycles is therefore healthy, even if its full period is longer than TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal RC reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External oscillator output, asynchronous to clk_ref |
| sw_osc_on | input | 1 | Software enable for the external oscillator |
| osc_ready | input | 1 | Oscillator startup-complete flag |
| mon_enable | input | 1 | Software arm bit for the monitor |
| flag_clr | input | 1 | Write-one clear for the failure flag |
| osc_enable | output | 1 | Effective oscillator enable after failure shutdown |
| mon_active | output | 1 | Monitor currently armed |
| brk_pulse | output | 1 | One-cycle break event for the timer |
| nmi_flag | output | 1 | Sticky failure flag for the non-maskable interrupt |

## Verification
The bench builds the block with TIMEOUT of 6, a two-stage synchroniser and both-edge detection. With this short window, the exact cycle of failure can be counted edge by edge from the moment of arming. A single well-timed transition just before the deadline can then be shown to push the failure out by a full window. Toggling the external clock every four reference cycles gives a period longer than the window but a half period shorter than it, so only both-edge detection keeps it healthy.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_BOTH = 1'b1
   } edge_mode_e;

   function automatic int cnt_bits(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
   parameter int                 STAGES = 2,
   parameter cfm_pkg::edge_mode_e MODE  = cfm_pkg::EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_seen
);

   // chain[STAGES-1] is the synchronised value, chain[STAGES] its history
   logic [STAGES:0] chain;
   logic            sync_now;
   logic            sync_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   assign sync_now = chain[STAGES-1];
   assign sync_old = chain[STAGES];

   generate
      if (MODE == cfm_pkg::EDGE_BOTH) begin : g_both
         assign edge_seen = sync_now ^ sync_old;
      end else begin : g_rise
         assign edge_seen = sync_now & ~sync_old;
      end
   endgenerate

endmodule

// File: rtl/cfm_gap_watch.sv
module cfm_gap_watch #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic edge_seen,
   output logic fail_now
);

   localparam int             CNT_W = cfm_pkg::cnt_bits(TIMEOUT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] gap_q;
   logic             at_limit;

   assign at_limit = (gap_q == LAST);
   assign fail_now = armed & ~edge_seen & at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gap_q <= '0;
      else if (!armed || edge_seen) gap_q <= '0;
      else if (at_limit)          gap_q <= '0;
      else                        gap_q <= gap_q + 1'b1;
   end

endmodule

// File: rtl/cfm_trip_ctrl.sv
module cfm_trip_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_now,
   input  logic sw_osc_on,
   input  logic flag_clr,
   output logic tripped,
   output logic brk_pulse,
   output logic nmi_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tripped <= 1'b0;
      else if (!sw_osc_on) tripped <= 1'b0;
      else if (fail_now)   tripped <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) brk_pulse <= 1'b0;
      else        brk_pulse <= fail_now;
   end

   // a fresh failure outranks a clear arriving on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        nmi_flag <= 1'b0;
      else if (fail_now) nmi_flag <= 1'b1;
      else if (flag_clr) nmi_flag <= 1'b0;
   end

endmodule

// File: rtl/ext_clk_fail_mon.sv
module ext_clk_fail_mon #(
   parameter int                  TIMEOUT     = 16,
   parameter int                  SYNC_STAGES = 2,
   parameter cfm_pkg::edge_mode_e EDGE_MODE   = cfm_pkg::EDGE_BOTH
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic sw_osc_on,
   input  logic osc_ready,
   input  logic mon_enable,
   input  logic flag_clr,
   output logic osc_enable,
   output logic mon_active,
   output logic brk_pulse,
   output logic nmi_flag
);

   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("TIMEOUT must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic edge_seen;
   logic fail_now;
   logic tripped;

   assign osc_enable = sw_osc_on & ~tripped;
   assign mon_active = mon_enable & osc_ready & osc_enable;

   cfm_edge_sync #(
      .STAGES (SYNC_STAGES),
      .MODE   (EDGE_MODE)
   ) sync_i (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .async_in  (ext_clk),
      .edge_seen (edge_seen)
   );

   cfm_gap_watch #(
      .TIMEOUT (TIMEOUT)
   ) watch_i (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .armed     (mon_active),
      .edge_seen (edge_seen),
      .fail_now  (fail_now)
   );

   cfm_trip_ctrl trip_i (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .fail_now  (fail_now),
      .sw_osc_on (sw_osc_on),
      .flag_clr  (flag_clr),
      .tripped   (tripped),
      .brk_pulse (brk_pulse),
      .nmi_flag  (nmi_flag)
   );

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
   input logic clk_ref,
   input logic rst_n,
   input logic sw_osc_on,
   input logic osc_ready,
   input logic mon_enable,
   input logic flag_clr,
   input logic osc_enable,
   input logic mon_active,
   input logic brk_pulse,
   input logic nmi_flag
);

   // R5: break lasts a single cycle
   a_r5_brk_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
      brk_pulse |=> !brk_pulse);

   // R8: break always accompanied by the sticky flag
   a_r8_brk_sets_flag: assert property (@(posedge clk_ref) disable iff (!rst_n)
      brk_pulse |-> nmi_flag);

   // R8: flag holds without a clear
   a_r8_flag_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (nmi_flag && !flag_clr) |=> nmi_flag);

   // R9: after a clear the flag survives only if a failure was just taken
   a_r9_clear_vs_fail: assert property (@(posedge clk_ref) disable iff (!rst_n)
      flag_clr |=> (nmi_flag == brk_pulse));

   // R6: failure shuts the oscillator off
   a_r6_brk_kills_osc: assert property (@(posedge clk_ref) disable iff (!rst_n)
      brk_pulse |-> !osc_enable);

   // R10: no failure without arming
   a_r10_no_fail_unarmed: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !mon_active |=> !brk_pulse);

   // R2 / R7: arming requires ready, enable and a running oscillator
   a_r2_arm_terms: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mon_active |-> (mon_enable && osc_ready && sw_osc_on));

endmodule

bind ext_clk_fail_mon cfm_checker chk_i (
   .clk_ref    (clk_ref),
   .rst_n      (rst_n),
   .sw_osc_on  (sw_osc_on),
   .osc_ready  (osc_ready),
   .mon_enable (mon_enable),
   .flag_clr   (flag_clr),
   .osc_enable (osc_enable),
   .mon_active (mon_active),
   .brk_pulse  (brk_pulse),
   .nmi_flag   (nmi_flag)
);

// File: tb/ext_clk_fail_mon_tb_top.sv
module ext_clk_fail_mon_tb_top;

   localparam int T = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_clk = 1'b0;
   logic sw_osc_on = 1'b0;
   logic osc_ready = 1'b0;
   logic mon_enable = 1'b0;
   logic flag_clr = 1'b0;
   logic osc_enable, mon_active, brk_pulse, nmi_flag;

   int  n_checks = 0;
   int  n_fails = 0;
   logic ext_run = 1'b0;
   int  ext_half = 4;
   int  ext_cnt = 0;
   logic timed_out = 1'b0;

   always #4 clk = ~clk;

   ext_clk_fail_mon #(
      .TIMEOUT     (T),
      .SYNC_STAGES (2),
      .EDGE_MODE   (cfm_pkg::EDGE_BOTH)
   ) dut_i (
      .clk_ref    (clk),
      .rst_n      (rst_n),
      .ext_clk    (ext_clk),
      .sw_osc_on  (sw_osc_on),
      .osc_ready  (osc_ready),
      .mon_enable (mon_enable),
      .flag_clr   (flag_clr),
      .osc_enable (osc_enable),
      .mon_active (mon_active),
      .brk_pulse  (brk_pulse),
      .nmi_flag   (nmi_flag)
   );

   always @(negedge clk) begin
      if (ext_run) begin
         ext_cnt = ext_cnt + 1;
         if (ext_cnt >= ext_half) begin
            ext_clk = ~ext_clk;
            ext_cnt = 0;
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // return to a quiet, disarmed state with the oscillator on and flag clear
   task automatic settle();
      mon_enable = 1'b0;
      ext_run    = 1'b0;
      sw_osc_on  = 1'b0;
      flag_clr   = 1'b1;
      cycles(1);
      flag_clr   = 1'b0;
      sw_osc_on  = 1'b1;
      osc_ready  = 1'b1;
      cycles(5);
   endtask

   task automatic t_reset();
      sw_osc_on = 1'b1;
      #1;
      chk("R1 brk", brk_pulse, 1'b0);
      chk("R1 nmi", nmi_flag, 1'b0);
      chk("R1 osc_enable", osc_enable, 1'b1);
      rst_n = 1'b1;
      cycles(3);
      chk("R1 brk after release", brk_pulse, 1'b0);
   endtask

   task automatic t_exact_timeout();
      settle();
      chk("R2 idle inactive", mon_active, 1'b0);
      mon_enable = 1'b1;
      #1;
      chk("R2 armed", mon_active, 1'b1);
      for (int i = 1; i <= T; i++) begin
         cycles(1);
         chk("R3 brk timing", brk_pulse, (i == T));
         chk("R6 osc timing", osc_enable, (i != T));
      end
      chk("R8 flag set", nmi_flag, 1'b1);
      chk("R2 disarmed after trip", mon_active, 1'b0);
      cycles(1);
      chk("R5 brk single", brk_pulse, 1'b0);
      cycles(10);
      chk("R8 flag sticky", nmi_flag, 1'b1);
      chk("R6 osc held off", osc_enable, 1'b0);
      flag_clr = 1'b1;
      cycles(1);
      flag_clr = 1'b0;
      chk("R8 flag cleared", nmi_flag, 1'b0);
      sw_osc_on = 1'b0;
      cycles(1);
      sw_osc_on = 1'b1;
      #1;
      chk("R6 osc restored", osc_enable, 1'b1);
   endtask

   task automatic t_restart();
      settle();
      mon_enable = 1'b1;
      cycles(2);
      ext_clk = ~ext_clk;   // one transition after the second armed edge
      for (int i = 3; i <= T + 5; i++) begin
         cycles(1);
         chk("R4 restart timing", brk_pulse, (i == T + 5));
      end
   endtask

   task automatic t_healthy_both();
      settle();
      ext_half = 4;
      ext_run  = 1'b1;
      cycles(6);
      mon_enable = 1'b1;
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 80; i++) begin
            cycles(1);
            if (brk_pulse) seen = 1'b1;
         end
         chk("R11 both edges keep alive", seen, 1'b0);
      end
      chk("R4 no flag on healthy clock", nmi_flag, 1'b0);
      chk("R4 osc still on", osc_enable, 1'b1);
      mon_enable = 1'b0;
      ext_run    = 1'b0;
      cycles(4);
   endtask

   task automatic t_disarm();
      settle();
      mon_enable = 1'b1;
      cycles(T - 2);
      sw_osc_on = 1'b0;
      #1;
      chk("R7 disarm on osc off", mon_active, 1'b0);
      cycles(3 * T);
      chk("R7 no fail when disarmed", nmi_flag, 1'b0);
      sw_osc_on = 1'b1;
      #1;
      chk("R2 rearm with osc on", mon_active, 1'b1);
      mon_enable = 1'b0;
      #1;
      chk("R2 off without enable", mon_active, 1'b0);
   endtask

   task automatic t_unarmed();
      settle();
      osc_ready  = 1'b0;
      mon_enable = 1'b1;
      #1;
      chk("R10 not armed before ready", mon_active, 1'b0);
      cycles(3 * T);
      chk("R10 no fail before ready", nmi_flag, 1'b0);
      mon_enable = 1'b0;
      osc_ready  = 1'b1;
      cycles(3 * T);
      chk("R10 no fail with enable off", nmi_flag, 1'b0);
      osc_ready  = 1'b0;
      mon_enable = 1'b1;
      cycles(2);
      osc_ready = 1'b1;
      cycles(T);
      chk("R10 fails once ready", brk_pulse, 1'b1);
   endtask

   task automatic t_collision();
      settle();
      mon_enable = 1'b1;
      cycles(T - 1);
      flag_clr = 1'b1;
      cycles(1);
      flag_clr = 1'b0;
      chk("R9 brk on collision", brk_pulse, 1'b1);
      chk("R9 failure beats clear", nmi_flag, 1'b1);
      flag_clr = 1'b1;
      cycles(1);
      flag_clr = 1'b0;
      chk("R9 clear after disarm", nmi_flag, 1'b0);
   endtask

   task automatic run_all();
      t_reset();
      t_exact_timeout();
      t_restart();
      t_healthy_both();
      t_disarm();
      t_unarmed();
      t_collision();
   endtask

   initial begin
      cycles(3);
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got hang expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule